// File: doc/BRIEF.md
# UART Receive Byte Queue with Level and Idle-Data Interrupt

This block holds received bytes of one asynchronous serial channel between the deserializer and the processor. The deserializer pushes bytes in and software pops them in arrival order. The read data is visible before the pop, so the head byte can be read at any time. The capacity is chosen at run time as 8 or 16 bytes. Status outputs show whether any byte is waiting, whether every position is filled, and whether a byte was lost.

A receiver interrupt request rises when the number of held bytes reaches a level. That level comes from a 2-bit code and the selected capacity, and it does not follow a straight line. The two bits of the code arrive on separate inputs because they come from different control fields. A second source, the idle-data timer, counts receive bit-time ticks while data waits unread. After 64 ticks with no access it raises the same interrupt. Without it, a short tail of a message below the level could stay unseen.

The code and the capacity are taken into use whenever the queue is empty, or on an accepted push or pop. A change made while bytes are held therefore waits for the next access.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset the queue is empty, and rx_rdy_o, rx_full_o, overrun_o and irq_o are all 0.
- R2: Bytes leave in the order they were accepted. pop_data_o shows the oldest held byte before it is popped.
- R3: Capacity is 8 when the active size select is 0 and 16 when it is 1. rx_full_o is 1 exactly when the held count equals the capacity, and rx_rdy_o is 1 whenever the count is non-zero.
- R4: A push into a full queue with no pop in the same cycle discards the byte and sets overrun_o. A push together with a pop on a full queue is accepted, and the count stays at capacity.
- R5: overrun_o stays set until a cycle with clr_ovr_i high. If a new overrun happens in that same cycle, the flag stays set.
- R6: A pop while the queue is empty is ignored.
- R7: The level code is {lvl_hi_i, lvl_lo_i}. At capacity 8, codes 0, 1, 2 and 3 raise irq_o at 1, 3, 6 and 8 or more bytes held.
- R8: At capacity 16, codes 0, 1, 2 and 3 raise irq_o at 1, 8, 12 and 16 or more bytes held.
- R9: While bytes are held, a change of the level code or size select takes effect only with the next accepted push or pop, sampled in that cycle.
- R10: With wd_en_i high and data held, irq_o rises after the edge that takes the 64th bit_tick_i since the last accepted push or pop. It does not rise after the 63rd. irq_o stays low when no data is held.
- R11: An accepted push or pop restarts the tick count. An access in the same cycle as the 64th tick prevents expiry. A pop clears an expired timer, but a push does not.
- R12: With wd_en_i low the timer never fires, and lowering wd_en_i clears an expired timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request from the deserializer |
| push_data_i | input | 8 | Byte to push |
| pop_i | input | 1 | Pop request from the processor |
| pop_data_o | output | 8 | Oldest held byte |
| deep_i | input | 1 | Size select: 0 gives 8 bytes, 1 gives 16 bytes |
| lvl_hi_i | input | 1 | Level code, upper bit |
| lvl_lo_i | input | 1 | Level code, lower bit |
| wd_en_i | input | 1 | Idle-data timer enable |
| bit_tick_i | input | 1 | One-cycle pulse per receive bit time |
| clr_ovr_i | input | 1 | Clears the overrun flag |
| rx_rdy_o | output | 1 | At least one byte held |
| rx_full_o | output | 1 | All positions filled |
| overrun_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Receiver interrupt request (level or timer) |

## Verification
Two events can collide in one cycle. First, the tick that would expire the idle-data timer can arrive together with an accepted pop. Second, a pop can arrive together with a push into a full queue. The bench lines up 63 ticks and then sends the 64th tick with a pop. The interrupt must stay low, and it must rise only after a further 64 ticks. In the second case it pushes and pops at capacity in one cycle. It then expects no overrun, a count still at capacity, and the new byte at the tail when the queue drains. It also puts a clear and a fresh overrun in the same cycle and expects the flag to stay set.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    LVL_ANY  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_ALL  = 2'd3
  } lvl_code_e;

  typedef struct packed {
    lvl_code_e code;
    logic      deep;
  } rxq_cfg_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CW-1:0]     count_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_i) rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({wr_i, rd_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_ptr_q];
  assign count_o   = count_q;
endmodule

// File: rtl/rxq_level.sv
module rxq_level
  import rxq_pkg::*;
#(
  parameter int SMALL     = 8,
  parameter int LARGE     = 16,
  parameter int SMALL_LOW = 3,
  localparam int CW = $clog2(LARGE + 1)
) (
  input  rxq_cfg_t      cfg_i,
  input  logic [CW-1:0] count_i,
  output logic          hit_o
);
  // non-linear table: low step is fixed on the small queue, half on the large
  localparam logic [CW-1:0] LARGE_LOW  = CW'(LARGE / 2);
  localparam logic [CW-1:0] SMALL_HIGH = CW'((3 * SMALL) / 4);
  localparam logic [CW-1:0] LARGE_HIGH = CW'((3 * LARGE) / 4);
  localparam logic [CW-1:0] SMALL_CAP  = CW'(SMALL);
  localparam logic [CW-1:0] LARGE_CAP  = CW'(LARGE);
  localparam logic [CW-1:0] S_LOW      = CW'(SMALL_LOW);

  logic [CW-1:0] thr;

  always_comb begin
    unique case (cfg_i.code)
      LVL_ANY:  thr = CW'(1);
      LVL_LOW:  thr = cfg_i.deep ? LARGE_LOW  : S_LOW;
      LVL_HIGH: thr = cfg_i.deep ? LARGE_HIGH : SMALL_HIGH;
      default:  thr = cfg_i.deep ? LARGE_CAP  : SMALL_CAP;
    endcase
  end

  assign hit_o = (count_i >= thr);
endmodule

// File: rtl/rxq_watchdog.sv
module rxq_watchdog #(
  parameter int LIMIT = 64,
  localparam int TW = $clog2(LIMIT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic active_i,
  input  logic restart_i,
  input  logic clear_i,
  output logic hit_o
);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;
  logic          hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (!en_i || !active_i) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      if (restart_i)             cnt_q <= '0;
      else if (tick_i && !hit_q) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

      if (clear_i)                                  hit_q <= 1'b0;
      else if (!restart_i && tick_i && cnt_q == LAST) hit_q <= 1'b1;
    end
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SMALL     = 8,
  parameter int LARGE     = 16,
  parameter int SMALL_LOW = 3,
  parameter int WD_LIMIT  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  input  logic              deep_i,
  input  logic              lvl_hi_i,
  input  logic              lvl_lo_i,
  input  logic              wd_en_i,
  input  logic              bit_tick_i,
  input  logic              clr_ovr_i,
  output logic              rx_rdy_o,
  output logic              rx_full_o,
  output logic              overrun_o,
  output logic              irq_o
);
  localparam int CW = $clog2(LARGE + 1);
  localparam logic [CW-1:0] SMALL_CAP = CW'(SMALL);
  localparam logic [CW-1:0] LARGE_CAP = CW'(LARGE);

  rxq_cfg_t      cfg_q;
  logic [CW-1:0] count_w;
  logic [CW-1:0] cap;
  logic          empty, full, push_acc, pop_acc, ovr_q, lvl_hit, wd_hit_w;

  assign cap      = cfg_q.deep ? LARGE_CAP : SMALL_CAP;
  assign empty    = (count_w == '0);
  assign full     = (count_w >= cap);
  assign pop_acc  = pop_i && !empty;
  assign push_acc = push_i && (!full || pop_acc);

  // new settings are adopted only when empty or on an accepted access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{code: LVL_ANY, deep: 1'b0};
    end else if (empty || push_acc || pop_acc) begin
      cfg_q.code <= lvl_code_e'({lvl_hi_i, lvl_lo_i});
      cfg_q.deep <= deep_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ovr_q <= 1'b0;
    else if (push_i && !push_acc)  ovr_q <= 1'b1;
    else if (clr_ovr_i)            ovr_q <= 1'b0;
  end

  rxq_store #(.DATA_W(DATA_W), .DEPTH(LARGE)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (push_acc),
    .wr_data_i (push_data_i),
    .rd_i      (pop_acc),
    .rd_data_o (pop_data_o),
    .count_o   (count_w)
  );

  rxq_level #(.SMALL(SMALL), .LARGE(LARGE), .SMALL_LOW(SMALL_LOW)) u_level (
    .cfg_i   (cfg_q),
    .count_i (count_w),
    .hit_o   (lvl_hit)
  );

  rxq_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (wd_en_i),
    .tick_i    (bit_tick_i),
    .active_i  (!empty),
    .restart_i (push_acc || pop_acc),
    .clear_i   (pop_acc),
    .hit_o     (wd_hit_w)
  );

  assign rx_rdy_o  = !empty;
  assign rx_full_o = full;
  assign overrun_o = ovr_q;
  assign irq_o     = lvl_hit || wd_hit_w;
endmodule

// File: rtl/rx_byte_queue_chk.sv
module rx_byte_queue_chk #(
  parameter int CW    = 5,
  parameter int LARGE = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic          clr_ovr_i,
  input logic          wd_en_i,
  input logic          rx_rdy_o,
  input logic          rx_full_o,
  input logic          overrun_o,
  input logic          irq_o,
  input logic [CW-1:0] count_w,
  input logic          wd_hit_w
);
  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_w) <= LARGE);
  a_r3_full_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o |-> rx_rdy_o);
  a_r4_full_push_sets_ovr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && rx_full_o && !pop_i |=> overrun_o);
  a_r5_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !clr_ovr_i |=> overrun_o);
  a_r6_pop_empty_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && !rx_rdy_o |=> !rx_rdy_o);
  a_r10_irq_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rx_rdy_o);
  a_r11_pop_clears_wd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && rx_rdy_o |=> !wd_hit_w);
  a_r12_wd_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en_i |=> !wd_hit_w);
endmodule

bind rx_byte_queue rx_byte_queue_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .push_i    (push_i),
  .pop_i     (pop_i),
  .clr_ovr_i (clr_ovr_i),
  .wd_en_i   (wd_en_i),
  .rx_rdy_o  (rx_rdy_o),
  .rx_full_o (rx_full_o),
  .overrun_o (overrun_o),
  .irq_o     (irq_o),
  .count_w   (count_w),
  .wd_hit_w  (wd_hit_w)
);

// File: tb/rx_byte_queue_bench.sv
`timescale 1ns/1ps
module rx_byte_queue_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       push_i = 1'b0, pop_i = 1'b0, deep_i = 1'b0;
  logic       lvl_hi_i = 1'b0, lvl_lo_i = 1'b0, wd_en_i = 1'b0;
  logic       bit_tick_i = 1'b0, clr_ovr_i = 1'b0;
  logic [7:0] push_data_i = '0;
  logic [7:0] pop_data_o;
  logic       rx_rdy_o, rx_full_o, overrun_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int cap = 8;
  logic [7:0] q[$];

  always #4 clk_i = ~clk_i;

  rx_byte_queue u_rx_byte_queue (
    .clk_i, .rst_ni, .push_i, .push_data_i, .pop_i, .pop_data_o,
    .deep_i, .lvl_hi_i, .lvl_lo_i, .wd_en_i, .bit_tick_i, .clr_ovr_i,
    .rx_rdy_o, .rx_full_o, .overrun_o, .irq_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic [7:0] d, input logic r, input logic t);
    push_i = p; push_data_i = d; pop_i = r; bit_tick_i = t;
    @(negedge clk_i);
    push_i = 1'b0; pop_i = 1'b0; bit_tick_i = 1'b0; clr_ovr_i = 1'b0;
  endtask

  task automatic push_m(input logic [7:0] d);
    step(1'b1, d, 1'b0, 1'b0);
    if (q.size() < cap) q.push_back(d);
  endtask

  task automatic pop_m(input string req);
    chk(req, int'(pop_data_o), int'(q[0]));
    step(1'b0, 8'h00, 1'b1, 1'b0);
    void'(q.pop_front());
  endtask

  task automatic drain(input string req);
    while (q.size() > 0) pop_m(req);
    chk(req, int'(rx_rdy_o), 0);
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) step(1'b0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic set_cfg(input int deep, input int code);
    deep_i = deep[0]; lvl_hi_i = code[1]; lvl_lo_i = code[0];
    cap = deep ? 16 : 8;
    step(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  function automatic int exp_thr(input int deep, input int code);
    int c = deep ? 16 : 8;
    if (code == 0) return 1;
    if (code == 3) return c;
    if (code == 2) return (c * 3) / 4;
    return deep ? c / 2 : 3;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1 rdy", int'(rx_rdy_o), 0);
    chk("R1 full", int'(rx_full_o), 0);
    chk("R1 ovr", int'(overrun_o), 0);
    chk("R1 irq", int'(irq_o), 0);

    // R7 R8 R3 R2: sweep every size and level code over every fill count
    for (int deep = 0; deep < 2; deep++) begin
      for (int code = 0; code < 4; code++) begin
        set_cfg(deep, code);
        for (int n = 1; n <= cap; n++) begin
          push_m(8'(n * 13 + code * 5 + deep * 97));
          chk(deep ? "R8 irq level" : "R7 irq level", int'(irq_o),
              int'(n >= exp_thr(deep, code)));
          chk("R3 full", int'(rx_full_o), int'(n == cap));
          chk("R3 rdy", int'(rx_rdy_o), 1);
        end
        drain("R2 order");
      end
    end

    // R6: pop on empty ignored
    set_cfg(0, 0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R6 rdy after empty pop", int'(rx_rdy_o), 0);
    push_m(8'hA5);
    chk("R6 single byte", int'(pop_data_o), 'hA5);
    drain("R6 drain");

    // R4 R5: overrun at capacity 8
    set_cfg(0, 0);
    for (int i = 0; i < 8; i++) push_m(8'(i + 1));
    push_m(8'hEE);
    chk("R4 ovr set", int'(overrun_o), 1);
    chk("R4 still full", int'(rx_full_o), 1);
    clr_ovr_i = 1'b1;
    push_m(8'hEF);
    chk("R5 set wins over clear", int'(overrun_o), 1);
    clr_ovr_i = 1'b1;
    step(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R5 cleared", int'(overrun_o), 0);
    // push with pop at full
    chk("R4 head", int'(pop_data_o), 1);
    step(1'b1, 8'h77, 1'b1, 1'b0);
    void'(q.pop_front());
    q.push_back(8'h77);
    chk("R4 push+pop no ovr", int'(overrun_o), 0);
    chk("R4 push+pop full", int'(rx_full_o), 1);
    drain("R4 discarded byte absent");

    // R9: deferred level change
    set_cfg(0, 0);
    push_m(8'h11);
    push_m(8'h22);
    lvl_hi_i = 1'b1; lvl_lo_i = 1'b0;
    step(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R9 old level held", int'(irq_o), 1);
    pop_m("R9 data");
    chk("R9 new level after pop", int'(irq_o), 0);
    for (int i = 0; i < 4; i++) push_m(8'(i + 40));
    chk("R9 five below six", int'(irq_o), 0);
    push_m(8'h55);
    chk("R9 six reaches level", int'(irq_o), 1);
    drain("R9 drain");

    // R10 R11 R12: idle-data timer, level code 3 at size 8
    set_cfg(0, 3);
    wd_en_i = 1'b1;
    ticks(70);
    chk("R10 no irq when empty", int'(irq_o), 0);
    push_m(8'h31);
    ticks(63);
    chk("R10 not at 63", int'(irq_o), 0);
    ticks(1);
    chk("R10 fires at 64", int'(irq_o), 1);
    chk("R10 rdy kept", int'(rx_rdy_o), 1);
    push_m(8'h32);
    chk("R11 push keeps flag", int'(irq_o), 1);
    pop_m("R11 data");
    chk("R11 pop clears", int'(irq_o), 0);
    push_m(8'h33);
    ticks(63);
    chk("R11 pre-collision", int'(irq_o), 0);
    chk("R11 head", int'(pop_data_o), 'h32);
    step(1'b0, 8'h00, 1'b1, 1'b1);
    void'(q.pop_front());
    chk("R11 access beats 64th tick", int'(irq_o), 0);
    ticks(63);
    chk("R11 restart 63", int'(irq_o), 0);
    ticks(1);
    chk("R11 restart 64", int'(irq_o), 1);
    wd_en_i = 1'b0;
    step(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R12 disable clears", int'(irq_o), 0);
    ticks(100);
    chk("R12 disabled never fires", int'(irq_o), 0);
    drain("R12 drain");

    finish_run();
  end
endmodule